// File: doc/BRIEF.md
# Maskable Interrupt Status Unit with Per-Source Clear

This block gathers twelve interrupt sources from a serial bus controller core into one raw status word and turns that word into a single interrupt line. Most sources are sticky: a one-cycle event pulse sets the bit, and the bit stays set until software clears it. Two sources are level-type. They track the receive-full and transmit-empty threshold levels of the FIFOs, so software can only clear them by servicing the FIFO.

A mask register gates the raw word into a masked status word, and the interrupt line is a registered OR of that masked word. Software clears sources by reading:

- Every sticky source has its own clear-on-read address.
- One more clear-on-read address clears all sticky sources at once.

A separate abort-cause register keeps the reason bits that the core reports when a transmission is aborted. That register empties when software reads the abort source's clear address or the clear-all address.

The bus side is a plain address, read strobe and write strobe port. Read data is combinational while the read strobe is high. The side effects of a read, and any write, take place at the clock edge that ends the access.

Top module: `irq_status_unit`

## Requirements
- R1: A high cycle on a sticky source input sets that bit of the raw status at the next clock edge, and the bit stays set until it is cleared. Raw bit order: 0 rx_under, 1 rx_over, 2 rx_full, 3 tx_over, 4 tx_empty, 5 rd_req, 6 tx_abrt, 7 rx_done, 8 activity, 9 stop_det, 10 start_det, 11 gen_call. Reading address 0x01 returns the raw status.
- R2: The masked status output `stat_masked` always equals raw AND mask, and reading address 0x00 returns the same value. A write to address 0x02 loads the mask from `bus_wdata[11:0]`. Reading 0x02 returns the mask.
- R3: Reading address 0x10+i (i = 0 to 11) returns the pre-clear value of raw bit i in read-data bit 0, with the upper bits zero. It clears only sticky bit i.
- R4: Reading address 0x04 returns the pre-clear raw status and clears every sticky bit.
- R5: Raw bits 2 (rx_full) and 4 (tx_empty) copy their input level one cycle late, and clear reads do not change them.
- R6: When a sticky source event and a clear read of that bit fall in the same cycle, the bit is set afterwards.
- R7: The abort-cause register ORs in the reason input bits at each clock edge and holds them. Meaningful bit positions:
  - 0: 7-bit address NACK
  - 1 and 2: first and second 10-bit address byte NACK
  - 3: data NACK
  - 4: general-call NACK
  - 5: general-call read
  - 7: start byte acknowledged
  - 9: start byte with restart disabled
  - 10: 10-bit read with restart disabled
  - 11: master disabled
  - 12: arbitration lost

  Bits 6 and 8 are never set. Reading address 0x03 returns the register.
- R8: A read of 0x16 (the tx_abrt clear) or of 0x04 empties the abort-cause register. Reason bits that arrive in that same cycle are kept.
- R9: `irq` is a registered OR of the masked status: it shows at each edge whether any masked bit was set in the cycle before.
- R10: Reads of 0x00, 0x01, 0x02 and 0x03 change no state. A read of any unmapped address returns zero and changes nothing.
- R11: After reset the raw status, the abort-cause register and `irq` are zero. The mask holds 0x254, which enables rx_full, tx_empty, tx_abrt and stop_det.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 12 | Per-source event pulses (sticky bits) or levels (bits 2 and 4) |
| abrt_reason | input | 13 | Abort reason pulses from the core |
| bus_addr | input | 6 | Register address |
| bus_rd | input | 1 | Read strobe; clear side effects at the edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 12 | Write data (mask) |
| bus_rdata | output | 13 | Combinational read data, zero when not reading |
| stat_masked | output | 12 | Raw status AND mask |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with its default parameters: twelve sources with level bits 2 and 4, a 13-bit abort-cause register with bits 6 and 8 reserved, and a 6-bit address. These defaults put every clear address, the two level-type sources and both reserved cause bits within reach. Directed sequences cover the following collisions:
- a set event colliding with its own clear read;
- a reason pulse colliding with the abort clear;
- clear reads aimed at level bits;
- unmapped reads.

A long random phase then mixes events, reason pulses, mask writes and clear reads across the whole address space.

// File: rtl/irq_status_pkg.sv
// Package: shared defaults, the address map and the read-select type of the
// interrupt status unit. Assumes an address bus of at least 5 bits.
package irq_status_pkg;

    localparam int SRC_COUNT   = 12;
    localparam int CAUSE_COUNT = 13;
    localparam int ADDR_BITS   = 6;

    localparam int ADR_MASKED  = 'h00;
    localparam int ADR_RAW     = 'h01;
    localparam int ADR_MASK    = 'h02;
    localparam int ADR_CAUSE   = 'h03;
    localparam int ADR_CLR_ALL = 'h04;
    localparam int ADR_CLR_BASE = 'h10;

    localparam logic [SRC_COUNT-1:0]   MASK_AT_RESET = 12'h254;
    localparam logic [SRC_COUNT-1:0]   LEVEL_SOURCES = 12'h014;
    localparam logic [CAUSE_COUNT-1:0] CAUSE_USED    = 13'h1EBF;
    localparam int                     ABORT_SRC     = 6;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_MASKED,
        RSEL_RAW,
        RSEL_MASK,
        RSEL_CAUSE,
        RSEL_CLR_ALL,
        RSEL_CLR_ONE
    } rsel_t;

endpackage

// File: rtl/irq_bus_decode.sv
// Module: irq_bus_decode
// Decodes the address/read/write port into per-source clear strobes, the
// abort-cause clear, the mask write enable and a read-mux select.
// Assumes read and write are not both high; a write needs no other qualifier.
module irq_bus_decode
    import irq_status_pkg::*;
#(
    parameter int NUM_SRC   = SRC_COUNT,
    parameter int ADDR_W    = ADDR_BITS,
    parameter int ABRT_IDX  = ABORT_SRC,
    localparam int IDX_W    = $clog2(NUM_SRC)
) (
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    output logic [NUM_SRC-1:0] clr_vec,
    output logic               clr_cause,
    output logic               mask_we,
    output rsel_t              rsel,
    output logic [IDX_W-1:0]   rsrc_idx
);

    logic [NUM_SRC-1:0] hit_one;
    logic               hit_all;

    assign hit_all = (bus_addr == ADDR_W'(ADR_CLR_ALL));

    // One comparator per source clear address.
    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
            assign hit_one[i] = (bus_addr == ADDR_W'(ADR_CLR_BASE + i));
            assign clr_vec[i] = bus_rd && (hit_one[i] || hit_all);
        end
    endgenerate

    assign clr_cause = bus_rd && (hit_one[ABRT_IDX] || hit_all);
    assign mask_we   = bus_wr && (bus_addr == ADDR_W'(ADR_MASK));
    assign rsrc_idx  = IDX_W'(bus_addr - ADDR_W'(ADR_CLR_BASE));

    // Pick the read source from the address while a read is active.
    always_comb begin
        rsel = RSEL_NONE;
        if (bus_rd) begin
            if (|hit_one)                                rsel = RSEL_CLR_ONE;
            else if (hit_all)                            rsel = RSEL_CLR_ALL;
            else if (bus_addr == ADDR_W'(ADR_MASKED))    rsel = RSEL_MASKED;
            else if (bus_addr == ADDR_W'(ADR_RAW))       rsel = RSEL_RAW;
            else if (bus_addr == ADDR_W'(ADR_MASK))      rsel = RSEL_MASK;
            else if (bus_addr == ADDR_W'(ADR_CAUSE))     rsel = RSEL_CAUSE;
        end
    end

endmodule

// File: rtl/irq_raw_bank.sv
// Module: irq_raw_bank
// Raw status flops, one per source. Sticky bits set on a pulse and clear on
// their strobe, with set winning; level bits copy their input each cycle.
// Assumes clr_vec is already qualified by the read strobe.
module irq_raw_bank
    import irq_status_pkg::*;
#(
    parameter int                  NUM_SRC    = SRC_COUNT,
    parameter logic [NUM_SRC-1:0]  LEVEL_BITS = LEVEL_SOURCES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] raw_q
);

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
            logic bit_q;
            assign raw_q[i] = bit_q;

            if (LEVEL_BITS[i]) begin : g_level
                // Follow the level input, one cycle late.
                always_ff @(posedge clk) begin
                    if (!rst_n) bit_q <= 1'b0;
                    else        bit_q <= src_in[i];
                end

                p_level_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
                    clr_vec[i] || !clr_vec[i] |=> (bit_q == $past(src_in[i])));
            end else begin : g_sticky
                // Hold until cleared; a same-cycle event overrides the clear.
                always_ff @(posedge clk) begin
                    if (!rst_n) bit_q <= 1'b0;
                    else        bit_q <= (bit_q && !clr_vec[i]) || src_in[i];
                end

                p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
                    (bit_q && !clr_vec[i]) |=> bit_q);
                p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
                    src_in[i] |=> bit_q);
                p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    (clr_vec[i] && !src_in[i]) |=> !bit_q);
            end
        end
    endgenerate

endmodule

// File: rtl/irq_abort_log.sv
// Module: irq_abort_log
// Accumulates abort reason bits until a clear read. Reserved positions are
// dropped at the input. Assumes clr is qualified by the read strobe.
module irq_abort_log
    import irq_status_pkg::*;
#(
    parameter int                 ABRT_W   = CAUSE_COUNT,
    parameter logic [ABRT_W-1:0]  USED_BITS = CAUSE_USED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ABRT_W-1:0] reason_in,
    input  logic              clr,
    output logic [ABRT_W-1:0] cause_q
);

    // Keep old causes unless cleared; new reasons always land.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (clr ? '0 : cause_q) | (reason_in & USED_BITS);
    end

    p_cause_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && reason_in == '0) |=> (cause_q == '0));
    p_cause_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

endmodule

// File: rtl/irq_status_unit.sv
// Module: irq_status_unit (top)
// Interrupt status unit: raw bank, abort-cause log, mask register, read mux
// and registered interrupt line. Read data is combinational during bus_rd;
// read side effects and writes land at the closing clock edge.
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int                  NUM_SRC    = SRC_COUNT,
    parameter int                  ABRT_W     = CAUSE_COUNT,
    parameter int                  ADDR_W     = ADDR_BITS,
    parameter int                  ABRT_IDX   = ABORT_SRC,
    parameter logic [NUM_SRC-1:0]  MASK_RESET = MASK_AT_RESET,
    parameter logic [NUM_SRC-1:0]  LEVEL_BITS = LEVEL_SOURCES,
    parameter logic [ABRT_W-1:0]   USED_BITS  = CAUSE_USED,
    localparam int RD_W  = (ABRT_W > NUM_SRC) ? ABRT_W : NUM_SRC,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [ABRT_W-1:0]  abrt_reason,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [RD_W-1:0]    bus_rdata,
    output logic [NUM_SRC-1:0] stat_masked,
    output logic               irq
);

    logic [NUM_SRC-1:0] clr_vec;
    logic               clr_cause;
    logic               mask_we;
    rsel_t              rsel;
    logic [IDX_W-1:0]   rsrc_idx;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [ABRT_W-1:0]  cause_q;

    irq_bus_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .ABRT_IDX(ABRT_IDX)) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .clr_vec  (clr_vec),
        .clr_cause(clr_cause),
        .mask_we  (mask_we),
        .rsel     (rsel),
        .rsrc_idx (rsrc_idx)
    );

    irq_raw_bank #(.NUM_SRC(NUM_SRC), .LEVEL_BITS(LEVEL_BITS)) u_raw (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_in (src_in),
        .clr_vec(clr_vec),
        .raw_q  (raw_q)
    );

    irq_abort_log #(.ABRT_W(ABRT_W), .USED_BITS(USED_BITS)) u_cause (
        .clk      (clk),
        .rst_n    (rst_n),
        .reason_in(abrt_reason),
        .clr      (clr_cause),
        .cause_q  (cause_q)
    );

    // Mask register, loaded by a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= MASK_RESET;
        else if (mask_we) mask_q <= bus_wdata;
    end

    assign stat_masked = raw_q & mask_q;

    // Registered interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |stat_masked;
    end

    // Read data multiplexer.
    always_comb begin
        unique case (rsel)
            RSEL_MASKED:  bus_rdata = RD_W'(stat_masked);
            RSEL_RAW:     bus_rdata = RD_W'(raw_q);
            RSEL_MASK:    bus_rdata = RD_W'(mask_q);
            RSEL_CAUSE:   bus_rdata = RD_W'(cause_q);
            RSEL_CLR_ALL: bus_rdata = RD_W'(raw_q);
            RSEL_CLR_ONE: bus_rdata = RD_W'(raw_q[rsrc_idx]);
            default:      bus_rdata = '0;
        endcase
    end

    p_irq_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(raw_q & mask_q))));
    p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(bus_wdata)));
    p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));

endmodule

// File: tb/irq_status_unit_tb_top.sv
// Bench: behavioural reference model stepped once per clock and compared on
// every cycle, plus directed checks against constants from the requirements.
module irq_status_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] src_in = '0;
    logic [12:0] abrt_reason = '0;
    logic [5:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_wdata = '0;
    logic [12:0] bus_rdata;
    logic [11:0] stat_masked;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference state
    logic [11:0] m_raw, m_mask;
    logic [12:0] m_cause;
    logic        m_irq;

    always #10 clk = ~clk;

    irq_status_unit dut_i (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .abrt_reason(abrt_reason),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stat_masked(stat_masked), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [12:0] model_read(input logic [5:0] a);
        if (a == 6'h00) return {1'b0, m_raw & m_mask};
        if (a == 6'h01) return {1'b0, m_raw};
        if (a == 6'h02) return {1'b0, m_mask};
        if (a == 6'h03) return m_cause;
        if (a == 6'h04) return {1'b0, m_raw};
        if (a >= 6'h10 && a < 6'h1C) return {12'b0, m_raw[a - 6'h10]};
        return '0;
    endfunction

    // One bus/clock cycle: drive, check read data, clock, step model, compare.
    task automatic cyc(input logic [11:0] s, input logic [12:0] r, input logic [5:0] a,
                       input logic rd, input logic wr, input logic [11:0] wd,
                       input logic use_k, input logic [12:0] k, input string ktag);
        logic [11:0] clr;
        logic        clra;
        logic [11:0] n_raw;
        logic        n_irq;
        src_in = s; abrt_reason = r; bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        #2;
        if (rd && rst_n) begin
            check("R10 read data vs model", 32'(bus_rdata), 32'(model_read(a)));
            if (use_k) check(ktag, 32'(bus_rdata), 32'(k));
        end
        @(posedge clk);
        if (!rst_n) begin
            m_raw = '0; m_mask = 12'h254; m_cause = '0; m_irq = 1'b0;
        end else begin
            clr = '0; clra = 1'b0;
            if (rd) begin
                if (a == 6'h04) begin clr = '1; clra = 1'b1; end
                else if (a >= 6'h10 && a < 6'h1C) begin
                    clr[a - 6'h10] = 1'b1;
                    if (a == 6'h16) clra = 1'b1;
                end
            end
            n_irq = |(m_raw & m_mask);
            for (int i = 0; i < 12; i++) begin
                if (i == 2 || i == 4) n_raw[i] = s[i];
                else                  n_raw[i] = (m_raw[i] && !clr[i]) || s[i];
            end
            m_cause = (clra ? 13'h0 : m_cause) | (r & 13'h1EBF);
            if (wr && a == 6'h02) m_mask = wd;
            m_raw = n_raw;
            m_irq = n_irq;
        end
        #1;
        check("R2 stat_masked vs model", 32'(stat_masked), 32'(m_raw & m_mask));
        check("R9 irq vs model", 32'(irq), 32'(m_irq));
        @(negedge clk);
    endtask

    task automatic idle();
        cyc('0, '0, 6'h3F, 1'b0, 1'b0, '0, 1'b0, '0, "");
    endtask

    task automatic rd_k(input logic [5:0] a, input logic [11:0] s, input logic [12:0] k, input string tag);
        cyc(s, '0, a, 1'b1, 1'b0, '0, 1'b1, k, tag);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) idle();
        rst_n = 1'b1;
        // R11 reset state
        check("R11 irq after reset", 32'(irq), 32'h0);
        rd_k(6'h02, '0, 13'h254, "R11 mask reset value");
        rd_k(6'h01, '0, 13'h000, "R11 raw reset value");
        rd_k(6'h03, '0, 13'h000, "R11 cause reset value");

        // R1 sticky set on pulses (bits 0,1,3)
        cyc(12'h00B, '0, 6'h3F, 1'b0, 1'b0, '0, 1'b0, '0, "");
        idle();
        rd_k(6'h01, '0, 13'h00B, "R1 raw after pulses");
        rd_k(6'h00, '0, 13'h000, "R2 masked with reset mask");
        // R2 mask write
        cyc('0, '0, 6'h02, 1'b0, 1'b1, 12'hFFF, 1'b0, '0, "");
        rd_k(6'h00, '0, 13'h00B, "R2 masked after mask write");
        check("R9 irq high after mask", 32'(irq), 32'h1);

        // R3 single-source clear
        rd_k(6'h11, '0, 13'h001, "R3 clear bit1 returns set");
        rd_k(6'h01, '0, 13'h009, "R3 only bit1 cleared");
        rd_k(6'h11, '0, 13'h000, "R3 second clear returns zero");

        // R5 level bit follows and ignores clear
        cyc(12'h004, '0, 6'h3F, 1'b0, 1'b0, '0, 1'b0, '0, "");
        rd_k(6'h01, 12'h004, 13'h00D, "R5 rx_full level visible");
        rd_k(6'h12, 12'h004, 13'h001, "R5 clear read of level bit");
        rd_k(6'h01, 12'h004, 13'h00D, "R5 level bit not cleared");
        rd_k(6'h01, 12'h000, 13'h00D, "R5 level still one cycle late");
        rd_k(6'h01, 12'h010, 13'h009, "R5 rx_full dropped");

        // R4 clear all, tx_empty level held
        rd_k(6'h04, 12'h010, 13'h019, "R4 clear-all returns pre-clear raw");
        rd_k(6'h01, 12'h010, 13'h010, "R4 only level bit remains");

        // R6 set wins over same-cycle clear
        cyc(12'h008, '0, 6'h13, 1'b1, 1'b0, '0, 1'b0, '0, "");
        rd_k(6'h01, '0, 13'h008, "R6 bit3 set despite clear");

        // R7 cause latching, reserved bits dropped
        cyc(12'h040, 13'h1FFF, 6'h3F, 1'b0, 1'b0, '0, 1'b0, '0, "");
        rd_k(6'h03, '0, 13'h1EBF, "R7 cause with reserved dropped");
        rd_k(6'h03, '0, 13'h1EBF, "R10 cause read has no side effect");

        // R8 clear via tx_abrt clear
        rd_k(6'h16, '0, 13'h001, "R8 tx_abrt clear returns set");
        rd_k(6'h03, '0, 13'h0000, "R8 cause emptied");
        rd_k(6'h01, '0, 13'h008, "R8 tx_abrt raw cleared");
        cyc('0, 13'h0008, 6'h16, 1'b1, 1'b0, '0, 1'b0, '0, "");
        rd_k(6'h03, '0, 13'h0008, "R8 reason kept over clear");
        cyc('0, 13'h1000, 6'h3F, 1'b0, 1'b0, '0, 1'b0, '0, "");
        rd_k(6'h04, '0, 13'h008, "R4 clear-all returns raw");
        rd_k(6'h03, '0, 13'h0000, "R8 cause emptied by clear-all");

        // R10 unmapped and status reads
        cyc(12'h200, '0, 6'h3F, 1'b0, 1'b0, '0, 1'b0, '0, "");
        rd_k(6'h3F, '0, 13'h000, "R10 unmapped reads zero");
        rd_k(6'h1C, '0, 13'h000, "R10 address past last clear reads zero");
        rd_k(6'h00, '0, 13'h200, "R10 masked read");
        rd_k(6'h01, '0, 13'h200, "R10 raw unchanged by reads");

        // R9 irq drops one cycle after mask cleared
        cyc('0, '0, 6'h02, 1'b0, 1'b1, 12'h000, 1'b0, '0, "");
        idle();
        check("R9 irq low after mask zero", 32'(irq), 32'h0);

        // Random phase
        for (int n = 0; n < 4000; n++) begin
            logic [11:0] s;
            logic [12:0] r;
            logic [5:0]  a;
            logic        rd, wr;
            s  = 12'($urandom) & 12'($urandom) & 12'($urandom);
            r  = ($urandom % 6 == 0) ? 13'($urandom) : 13'h0;
            a  = ($urandom % 4 == 0) ? 6'($urandom) : 6'(16 + $urandom % 12);
            wr = ($urandom % 10 == 0);
            if (wr) a = 6'h02;
            rd = !wr && ($urandom % 2 == 0);
            cyc(s, r, a, rd, wr, 12'($urandom), 1'b0, '0, "");
        end
        finish_run();
    end

endmodule